// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a four-common, 1/3-bias, 1/4-duty multiplexed liquid-crystal panel. It holds the display picture in a small register-file memory that the processor writes through a byte port. It scans the commons one after another and places a 2-bit bias-level code on every common and segment pin. Each frame the polarity of all levels is mirrored, so the panel sees no net DC. An external ladder and pad stage turn the codes into voltages. The level codes are 0 for V0, 1 for V1/3, 2 for V2/3 and 3 for V3.

The processor turns the panel on and off with two single-cycle strobes and picks one of four frame rates with a 2-bit select. It writes picture bytes at any time, and they appear on the pins with no further action. The four highest segment pins can be handed over to act as plain output port bits.

Top module: `lcd_mux_driver`

## Requirements
- R1: After reset the panel is off. While off, every common and segment pin carries code 0, except the port-mode pins covered by R8.
- R2: A pulse on `lcd_on_i` turns the panel on and a pulse on `lcd_off_i` turns it off. When both pulse in the same cycle, off wins. The pins follow the new state from the second rising edge after the pulse edge.
- R3: While on, the selected common steps 0, 1, 2, 3, 0, … and starts at common 0. Each common is held for L = DIV_BASE·2^(3−`rate_sel_i`) cycles, so select 0 is the slowest rate (64 Hz class) and select 3 the fastest (512 Hz class).
- R4: Common codes in even frames are 3 on the selected common and 1 on the others. In odd frames they are mirrored to 0 and 2.
- R5: The first frame after power-on is even, and the polarity flips each time the scan leaves common 3.
- R6: A segment pixel is lit when bit c of its nibble is 1, where c is the selected common. In even frames a lit segment carries code 0 and a dark one carries code 2. In odd frames these become 3 and 1.
- R7: Picture byte k is written at address BASE+k, for k from 0 to 17. Bits 3:0 of the byte hold segment 2k and bits 7:4 hold segment 2k+1. A write shows on the pins from the second rising edge after the write edge. Writes to any other address change nothing.
- R8: With `port_mode_i`=1, segment pin 32+i carries code 3 when `port_val_i[i]` is 1 and code 0 when it is 0. This holds whether the panel is on or off and takes effect one edge later. With `port_mode_i`=0 the port value is ignored.
- R9: The picture memory keeps its contents while the panel is off and on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_on_i | input | 1 | Turn-on strobe |
| lcd_off_i | input | 1 | Turn-off strobe (dominant) |
| rate_sel_i | input | 2 | Frame-rate select, 0 slowest … 3 fastest |
| wr_en_i | input | 1 | Picture write strobe |
| wr_addr_i | input | 8 | Picture write address |
| wr_data_i | input | 8 | Picture write data (two segment nibbles) |
| port_mode_i | input | 1 | 1: top four segment pins act as port bits |
| port_val_i | input | 4 | Port bit values for segment pins 35..32 |
| com_o | output | 8 | Common level codes, 2 bits per common |
| seg_o | output | 72 | Segment level codes, 2 bits per segment |

## Verification
On/off strobes and picture writes each pass through one state register and then the output register. The bench therefore samples their effect at the falling edge after the second rising edge, and for a write it also confirms that the pins have not moved after the first edge. Port values pass only the output register and are checked one edge later. The scan is checked every cycle against a schedule that starts on the first output edge after turn-on. In that schedule step s lasts exactly L cycles, has common s mod 4 and has polarity (s/4) mod 2, so a step that comes one cycle early or late is caught.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_V0  = 2'd0;
  localparam lvl_t LVL_V13 = 2'd1;
  localparam lvl_t LVL_V23 = 2'd2;
  localparam lvl_t LVL_V3  = 2'd3;

  // Odd frames mirror each level about the ladder midpoint.
  function automatic lvl_t lvl_mirror(lvl_t l, logic odd);
    return odd ? ~l : l;
  endfunction
endpackage

// File: rtl/lcd_rate_div.sv
module lcd_rate_div #(
  parameter int DIV_BASE = 16,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             tick_o
);
  localparam int MAX_SH  = (1 << SEL_W) - 1;
  localparam int MAX_LIM = DIV_BASE << MAX_SH;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim    = CNT_W'(DIV_BASE) << (SEL_W'(MAX_SH) - rate_sel_i);
    tick_o = en_i && (cnt_q >= lim - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i)   cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  generate
    if (DIV_BASE > 1) begin : g_spacing
      assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl #(
  parameter int NCOM = 4,
  localparam int CW  = $clog2(NCOM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          on_i,
  input  logic          off_i,
  input  logic          tick_i,
  output logic          en_o,
  output logic [CW-1:0] com_o,
  output logic          odd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_o  <= 1'b0;
      com_o <= '0;
      odd_o <= 1'b0;
    end else begin
      if (off_i)      en_o <= 1'b0;
      else if (on_i)  en_o <= 1'b1;

      if (!en_o || off_i) begin
        com_o <= '0;
        odd_o <= 1'b0;
      end else if (tick_i) begin
        if (com_o == CW'(NCOM - 1)) begin
          com_o <= '0;
          odd_o <= ~odd_o;
        end else begin
          com_o <= com_o + CW'(1);
        end
      end
    end
  end

  assert_com_hold_R3: assert property (@(posedge clk) disable iff (rst)
    en_o && !tick_i && !off_i |=> $stable(com_o));
  assert_pol_flip_R5: assert property (@(posedge clk) disable iff (rst)
    en_o && !off_i && tick_i && com_o == CW'(NCOM - 1) |=> odd_o != $past(odd_o));
  assert_pol_hold_R5: assert property (@(posedge clk) disable iff (rst)
    en_o && !off_i && !(tick_i && com_o == CW'(NCOM - 1)) |=> $stable(odd_o));
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int NSEG   = 36,
  parameter int NCOM   = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hEE
) (
  input  logic               clk,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [7:0]         wr_data_i,
  output logic [NSEG*NCOM-1:0] pix_o
);
  localparam int SPB   = 8 / NCOM;
  localparam int NBYTE = NSEG / SPB;
  localparam int IDX_W = $clog2(NBYTE);

  logic [7:0]        mem_q [NBYTE];
  logic [ADDR_W-1:0] off_w;
  logic [IDX_W-1:0]  idx_w;
  logic              hit_w;

  always_comb begin
    off_w = wr_addr_i - BASE;
    hit_w = wr_en_i && (off_w < ADDR_W'(NBYTE));
    idx_w = off_w[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (hit_w) mem_q[idx_w] <= wr_data_i;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    for (genvar c = 0; c < NCOM; c++) begin : g_com
      assign pix_o[s*NCOM + c] = mem_q[s / SPB][(s % SPB)*NCOM + c];
    end
  end

  assert_write_lands_R7: assert property (@(posedge clk)
    hit_w |=> mem_q[$past(idx_w)] == $past(wr_data_i));
endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NSEG     = 36,
  parameter int NCOM     = 4,
  parameter int NPORT    = 4,
  parameter int DIV_BASE = 16,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hEE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lcd_on_i,
  input  logic                lcd_off_i,
  input  logic [1:0]          rate_sel_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic                port_mode_i,
  input  logic [NPORT-1:0]    port_val_i,
  output logic [2*NCOM-1:0]   com_o,
  output logic [2*NSEG-1:0]   seg_o
);
  import lcd_pkg::*;
  localparam int CW = $clog2(NCOM);

  logic              tick_w, en_w, odd_w;
  logic [CW-1:0]     com_w;
  logic [NSEG*NCOM-1:0] pix_w;

  lcd_rate_div #(.DIV_BASE(DIV_BASE), .SEL_W(2)) u_div (
    .clk(clk), .rst(rst), .en_i(en_w), .rate_sel_i(rate_sel_i), .tick_o(tick_w));

  lcd_scan_ctrl #(.NCOM(NCOM)) u_scan (
    .clk(clk), .rst(rst), .on_i(lcd_on_i), .off_i(lcd_off_i), .tick_i(tick_w),
    .en_o(en_w), .com_o(com_w), .odd_o(odd_w));

  lcd_disp_ram #(.NSEG(NSEG), .NCOM(NCOM), .ADDR_W(ADDR_W), .BASE(BASE)) u_ram (
    .clk(clk), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pix_o(pix_w));

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst || !en_w) com_o[2*i +: 2] <= LVL_V0;
      else com_o[2*i +: 2] <= lvl_mirror((com_w == CW'(i)) ? LVL_V3 : LVL_V13, odd_w);
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s >= NSEG - NPORT) begin : g_port
      always_ff @(posedge clk) begin
        if (rst) seg_o[2*s +: 2] <= LVL_V0;
        else if (port_mode_i) seg_o[2*s +: 2] <= {2{port_val_i[s - (NSEG - NPORT)]}};
        else if (!en_w) seg_o[2*s +: 2] <= LVL_V0;
        else seg_o[2*s +: 2] <= lvl_mirror(pix_w[s*NCOM + com_w] ? LVL_V0 : LVL_V23, odd_w);
      end
      assert_port_follow_R8: assert property (@(posedge clk) disable iff (rst)
        port_mode_i |=> seg_o[2*s +: 2] == {2{$past(port_val_i[s - (NSEG - NPORT)])}});
    end else begin : g_lcd
      always_ff @(posedge clk) begin
        if (rst || !en_w) seg_o[2*s +: 2] <= LVL_V0;
        else seg_o[2*s +: 2] <= lvl_mirror(pix_w[s*NCOM + com_w] ? LVL_V0 : LVL_V23, odd_w);
      end
    end
  end

  logic [NCOM-1:0] com_edge;
  always_comb begin
    for (int i = 0; i < NCOM; i++)
      com_edge[i] = (com_o[2*i +: 2] == LVL_V0) || (com_o[2*i +: 2] == LVL_V3);
  end

  assert_one_selected_R4: assert property (@(posedge clk) disable iff (rst)
    en_w |=> $countones(com_edge) == 1);
  assert_off_blank_R1: assert property (@(posedge clk) disable iff (rst)
    !en_w |=> com_o == '0);
endmodule

// File: tb/lcd_mux_driver_tb.sv
module lcd_mux_driver_tb_top;
  localparam int NSEG = 36, NCOM = 4, NPORT = 4, DIV_BASE = 2, NBYTE = 18;
  localparam logic [7:0] BASE = 8'hEE;

  logic clk = 1'b0, rst = 1'b1;
  logic lcd_on = 0, lcd_off = 0, wr_en = 0, port_mode = 0;
  logic [1:0] rate_sel = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [3:0] port_val = 0;
  logic [2*NCOM-1:0] com_o;
  logic [2*NSEG-1:0] seg_o;
  logic [7:0] mem_model [NBYTE];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_mux_driver #(.NSEG(NSEG), .NCOM(NCOM), .NPORT(NPORT), .DIV_BASE(DIV_BASE),
                   .ADDR_W(8), .BASE(BASE)) dut_i (
    .clk(clk), .rst(rst), .lcd_on_i(lcd_on), .lcd_off_i(lcd_off), .rate_sel_i(rate_sel),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .port_mode_i(port_mode),
    .port_val_i(port_val), .com_o(com_o), .seg_o(seg_o));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*NCOM-1:0] exp_com(bit on, int com, bit odd);
    logic [2*NCOM-1:0] v = '0;
    for (int i = 0; i < NCOM; i++) begin
      logic [1:0] l = (i == com) ? 2'd3 : 2'd1;
      v[2*i +: 2] = on ? (odd ? 2'd3 - l : l) : 2'd0;
    end
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg(bit on, int com, bit odd);
    logic [2*NSEG-1:0] v = '0;
    for (int s = 0; s < NSEG; s++) begin
      bit px = mem_model[s/2][(s%2)*4 + com];
      logic [1:0] l = px ? 2'd0 : 2'd2;
      if (port_mode && s >= NSEG - NPORT)
        v[2*s +: 2] = port_val[s - (NSEG - NPORT)] ? 2'd3 : 2'd0;
      else
        v[2*s +: 2] = on ? (odd ? 2'd3 - l : l) : 2'd0;
    end
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int off = int'(a) - int'(BASE);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    if (off >= 0 && off < NBYTE) mem_model[off] = d;
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < NBYTE; k++) wr(BASE + 8'(k), 8'((k * 59 + seed * 23) ^ 8'hA5));
  endtask

  task automatic pulse(input bit on, input bit off);
    @(negedge clk); lcd_on = on; lcd_off = off;
    @(posedge clk);
    @(negedge clk); lcd_on = 0; lcd_off = 0;
  endtask

  // Turn on, follow the scan for nsteps common steps, then turn off.
  task automatic run_scan(input int sel, input int nsteps, input string tag);
    int len = DIV_BASE << (3 - sel);
    rate_sel = 2'(sel);
    pulse(1, 0);
    @(posedge clk);
    for (int s = 0; s < nsteps; s++) begin
      for (int c = 0; c < len; c++) begin
        @(negedge clk);
        chk("R3 R4 R5 commons", com_o, exp_com(1, s % 4, bit'((s / 4) % 2)));
        chk({tag, " segments"}, seg_o, exp_seg(1, s % 4, bit'((s / 4) % 2)));
        @(posedge clk);
      end
    end
    pulse(0, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 off blanks commons", com_o, exp_com(0, 0, 0));
    chk("R2 off blanks segments", seg_o, exp_seg(0, 0, 0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); @(negedge clk);
    chk("R1 reset commons", com_o, '0);
    chk("R1 reset segments", seg_o, '0);

    fill(1);
    @(posedge clk); @(negedge clk);
    chk("R1 off with data", seg_o, '0);

    // R3 R6 R8: every rate, port value ignored in segment mode
    port_val = 4'hF;
    for (int sel = 0; sel < 4; sel++) begin
      fill(sel + 2);
      run_scan(sel, 8, "R6 R8");
    end

    // R8 port pins while off, one edge latency
    @(negedge clk); port_mode = 1; port_val = 4'b1001;
    @(posedge clk); @(negedge clk);
    chk("R8 port while off", seg_o, exp_seg(0, 0, 0));
    port_val = 4'b0110;
    @(posedge clk); @(negedge clk);
    chk("R8 port change", seg_o, exp_seg(0, 0, 0));
    run_scan(3, 8, "R8 port mode");
    port_mode = 0;

    // R7 write latency while running: step 0 of slowest rate
    wr(BASE, 8'h00);
    rate_sel = 0;
    pulse(1, 0);
    @(posedge clk);
    @(negedge clk); wr_en = 1; wr_addr = BASE; wr_data = 8'h0F;
    @(posedge clk);
    @(negedge clk); wr_en = 0;
    chk("R7 write not yet visible", seg_o, exp_seg(1, 0, 0));
    mem_model[0] = 8'h0F;
    @(posedge clk); @(negedge clk);
    chk("R7 write visible", seg_o, exp_seg(1, 0, 0));
    pulse(0, 1);
    @(posedge clk);

    // R7 out-of-range writes change nothing
    wr(BASE - 8'd1, 8'hFF);
    wr(8'h00, 8'h5A);
    wr(8'h10, 8'hC3);
    run_scan(3, 4, "R7 out of range");

    // R9 contents survive off/on
    run_scan(2, 4, "R9 retention");

    // R2 simultaneous on and off: stays off
    pulse(1, 1);
    @(posedge clk); @(negedge clk);
    chk("R2 on+off commons", com_o, '0);
    chk("R2 on+off segments", seg_o, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule